// File: doc/BRIEF.md
# Permuted 3D element index generator

This block turns a plain element loop into a walk through a small three-dimensional array. A configuration word gives three dimension sizes, a loop-nesting permutation and a 3-bit offset. After a start, each step request yields the next remapped element index. That index is formed from three dimension counters. The counters carry into one another in the nesting order the permutation selects. A vector-length input sets how many steps make up one operation. When that many steps have been taken, done asserts.

The block checks every index against the size of the register file, and it checks the permutation code. A violation raises an illegal flag and halts the walk. The walk can be interrupted at any step. Its whole loop position (the three counters plus the step count) is always visible on a save bus. A later restore request reloads that position from a load bus, and the walk then carries on with the next step exactly where it stopped.

Top module: `perm_index_walker`

## Requirements
- R1: After reset, idx_valid, done and illegal are 0 and idx_out is 0.
- R2: Configuration fields: x size at bits 6:0, y size at bits 14:8, z size at bits 22:16, each holding the size minus one. The offset is {bit 23, bit 15, bit 7} (bit 7 is the LSB). The permute code is at bits 26:24.
- R3: Each accepted step drives idx_out = offs + ix + iy*X + iz*X*Y one cycle later, with idx_valid high for that single cycle. X and Y are the decoded x and y sizes. The counters start at zero on start.
- R4: After each step the innermost counter of the selected order increments. On reaching its size it returns to zero and carries outward. Orders from innermost: 0=(x,y,z), 1=(x,z,y), 2=(y,x,z), 3=(y,z,x), 4=(z,x,y), 5=(z,y,x).
- R5: An all-zero configuration word gives a linear mapping: the k-th step (counting from 0) yields index k.
- R6: When the product of the sizes is below the vector length, the index sequence wraps and repeats with no illegal flag.
- R7: A start or restore with permute code 6 or 7 raises illegal one cycle later, and the steps that follow produce no idx_valid.
- R8: A step whose index would be at or above REG_ELEMS produces no idx_valid. It raises illegal and leaves the loop position unchanged on pos_save.
- R9: done rises in the same cycle as the idx_valid of step number vec_len. Further steps produce no idx_valid until the next start or restore.
- R10: pos_save = {step count (bits 28:21), z counter (20:14), y counter (13:7), x counter (6:0)}. A restore loads pos_load into this position, and the next step yields the index of the loaded position.
- R11: In a cycle with no start, step or restore, idx_out and pos_save hold and idx_valid is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_in | input | 27 | Shape configuration word, captured on start or restore |
| vec_len | input | 8 | Number of steps in the operation, captured on start or restore |
| start | input | 1 | Begin a new walk from position zero |
| step | input | 1 | Produce the next index |
| restore | input | 1 | Resume from the position on pos_load |
| pos_load | input | 29 | Loop position to resume from |
| pos_save | output | 29 | Current loop position |
| idx_out | output | 23 | Remapped element index |
| idx_valid | output | 1 | idx_out updated by a step in the previous cycle |
| done | output | 1 | Requested number of steps taken |
| illegal | output | 1 | Bad permute code or register-file overrun |

## Verification
Every result is registered, so each one is due in the first cycle after the clock edge that samples the start, step or restore request. That covers an index with its valid strobe, done after the final step, illegal after a bad code or an overrun, and the restored position on pos_save. The bench changes inputs on the falling edge and reads outputs at the following falling edge, which keeps each check exactly one register stage behind its stimulus. For back-to-back steps it keeps step high and checks every cycle.

// File: rtl/perm_walk_pkg.sv
package perm_walk_pkg;

    typedef enum logic [1:0] {
        DIM_X = 2'd0,
        DIM_Y = 2'd1,
        DIM_Z = 2'd2
    } dim_e;

    // entry 0 is the innermost loop, entry 2 the outermost
    typedef dim_e [2:0] order_t;

    localparam int PERM_W = 3;

    function automatic logic perm_is_bad(input logic [PERM_W-1:0] code);
        return code > 3'd5;
    endfunction

    function automatic order_t order_of(input logic [PERM_W-1:0] code);
        order_t o;
        case (code)
            3'd1:    o = '{DIM_Y, DIM_Z, DIM_X};
            3'd2:    o = '{DIM_Z, DIM_X, DIM_Y};
            3'd3:    o = '{DIM_X, DIM_Z, DIM_Y};
            3'd4:    o = '{DIM_Y, DIM_X, DIM_Z};
            3'd5:    o = '{DIM_X, DIM_Y, DIM_Z};
            default: o = '{DIM_Z, DIM_Y, DIM_X};
        endcase
        return o;
    endfunction

endpackage

// File: rtl/pw_cfg_decode.sv
module pw_cfg_decode
    import perm_walk_pkg::*;
#(
    parameter int DIM_W = 7,
    localparam int SLOT_W = DIM_W + 1,
    localparam int CFG_W = 3 * SLOT_W + PERM_W
) (
    input  logic [CFG_W-1:0]        cfg,
    output logic [2:0][DIM_W:0]     lim,
    output logic [2:0]              offs,
    output order_t                  order,
    output logic                    linear
);

    localparam int PERM_LSB = 3 * SLOT_W;

    for (genvar g = 0; g < 3; g++) begin : g_slot
        logic [DIM_W-1:0] size_m1;
        assign size_m1 = cfg[g*SLOT_W +: DIM_W];
        assign lim[g]  = {1'b0, size_m1} + {{DIM_W{1'b0}}, 1'b1};
        assign offs[g] = cfg[g*SLOT_W + DIM_W];
    end

    assign order  = order_of(cfg[PERM_LSB +: PERM_W]);
    assign linear = (cfg == '0);

endmodule

// File: rtl/pw_dim_step.sv
module pw_dim_step
    import perm_walk_pkg::*;
#(
    parameter int DIM_W = 7
) (
    input  logic [2:0][DIM_W-1:0] cnt,
    input  logic [2:0][DIM_W:0]   lim,
    input  order_t                order,
    output logic [2:0][DIM_W-1:0] nxt
);

    always_comb begin
        logic carry;
        int   d;
        nxt   = cnt;
        carry = 1'b1;
        for (int p = 0; p < 3; p++) begin
            d = int'(order[p]);
            if (carry) begin
                if (({1'b0, cnt[d]} + {{DIM_W{1'b0}}, 1'b1}) >= lim[d]) begin
                    nxt[d] = '0;
                end else begin
                    nxt[d] = cnt[d] + {{(DIM_W-1){1'b0}}, 1'b1};
                    carry  = 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/pw_index_calc.sv
module pw_index_calc #(
    parameter int DIM_W = 7,
    parameter int CNT_W = 8,
    parameter int IDX_W = 3 * DIM_W + 2
) (
    input  logic [2:0][DIM_W-1:0] cnt,
    input  logic [DIM_W:0]        lim_x,
    input  logic [DIM_W:0]        lim_y,
    input  logic [2:0]            offs,
    input  logic                  linear,
    input  logic [CNT_W-1:0]      count,
    output logic [IDX_W-1:0]      idx
);

    logic [2*DIM_W+1:0] plane;
    logic [IDX_W-1:0]   row_part;
    logic [IDX_W-1:0]   plane_part;

    assign plane      = lim_x * lim_y;
    assign row_part   = IDX_W'(cnt[1]) * IDX_W'(lim_x);
    assign plane_part = IDX_W'(cnt[2]) * IDX_W'(plane);

    always_comb begin
        if (linear) begin
            idx = IDX_W'(count);
        end else begin
            idx = IDX_W'(offs) + IDX_W'(cnt[0]) + row_part + plane_part;
        end
    end

endmodule

// File: rtl/perm_index_walker.sv
module perm_index_walker
    import perm_walk_pkg::*;
#(
    parameter int DIM_W     = 7,
    parameter int CNT_W     = 8,
    parameter int REG_ELEMS = 128,
    localparam int CFG_W = 3 * (DIM_W + 1) + PERM_W,
    localparam int IDX_W = 3 * DIM_W + 2,
    localparam int POS_W = CNT_W + 3 * DIM_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg_in,
    input  logic [CNT_W-1:0] vec_len,
    input  logic             start,
    input  logic             step,
    input  logic             restore,
    input  logic [POS_W-1:0] pos_load,
    output logic [POS_W-1:0] pos_save,
    output logic [IDX_W-1:0] idx_out,
    output logic             idx_valid,
    output logic             done,
    output logic             illegal
);

    localparam int PERM_LSB = 3 * (DIM_W + 1);

    typedef struct packed {
        logic [CFG_W-1:0]        cfg;
        logic [CNT_W-1:0]        len;
        logic [2:0][DIM_W-1:0]   cnt;
        logic [CNT_W-1:0]        count;
        logic                    busy;
        logic [IDX_W-1:0]        idx;
        logic                    valid;
        logic                    done;
        logic                    illegal;
    } walk_t;

    walk_t walk_d, walk_q;

    logic [2:0][DIM_W:0]   lim;
    logic [2:0]            offs;
    order_t                order;
    logic                  linear;
    logic [2:0][DIM_W-1:0] cnt_nxt;
    logic [IDX_W-1:0]      idx_now;
    logic                  overrun;
    logic                  cfg_bad_in;
    logic [CNT_W-1:0]      count_inc;
    logic [CNT_W-1:0]      load_count;
    logic [2:0][DIM_W-1:0] load_cnt;

    pw_cfg_decode #(.DIM_W(DIM_W)) u_decode (
        .cfg    (walk_q.cfg),
        .lim    (lim),
        .offs   (offs),
        .order  (order),
        .linear (linear)
    );

    pw_dim_step #(.DIM_W(DIM_W)) u_step (
        .cnt   (walk_q.cnt),
        .lim   (lim),
        .order (order),
        .nxt   (cnt_nxt)
    );

    pw_index_calc #(.DIM_W(DIM_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_index (
        .cnt    (walk_q.cnt),
        .lim_x  (lim[0]),
        .lim_y  (lim[1]),
        .offs   (offs),
        .linear (linear),
        .count  (walk_q.count),
        .idx    (idx_now)
    );

    assign cfg_bad_in = perm_is_bad(cfg_in[PERM_LSB +: PERM_W]);
    assign overrun    = (idx_now >= IDX_W'(REG_ELEMS));
    assign count_inc  = walk_q.count + CNT_W'(1);
    assign load_count = pos_load[POS_W-1 -: CNT_W];
    assign load_cnt   = pos_load[3*DIM_W-1:0];

    always_comb begin
        walk_d       = walk_q;
        walk_d.valid = 1'b0;
        if (start) begin
            walk_d.cfg     = cfg_in;
            walk_d.len     = vec_len;
            walk_d.cnt     = '0;
            walk_d.count   = '0;
            walk_d.illegal = cfg_bad_in;
            walk_d.done    = (vec_len == '0);
            walk_d.busy    = !cfg_bad_in && (vec_len != '0);
        end else if (restore) begin
            walk_d.cfg     = cfg_in;
            walk_d.len     = vec_len;
            walk_d.cnt     = load_cnt;
            walk_d.count   = load_count;
            walk_d.illegal = cfg_bad_in;
            walk_d.done    = (load_count >= vec_len);
            walk_d.busy    = !cfg_bad_in && (load_count < vec_len);
        end else if (step && walk_q.busy) begin
            if (overrun) begin
                walk_d.illegal = 1'b1;
                walk_d.busy    = 1'b0;
            end else begin
                walk_d.idx   = idx_now;
                walk_d.valid = 1'b1;
                walk_d.count = count_inc;
                if (!linear) begin
                    walk_d.cnt = cnt_nxt;
                end
                if (count_inc == walk_q.len) begin
                    walk_d.done = 1'b1;
                    walk_d.busy = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            walk_q <= '0;
        end else begin
            walk_q <= walk_d;
        end
    end

    assign pos_save  = {walk_q.count, walk_q.cnt};
    assign idx_out   = walk_q.idx;
    assign idx_valid = walk_q.valid;
    assign done      = walk_q.done;
    assign illegal   = walk_q.illegal;

endmodule

// File: rtl/pw_checker.sv
module pw_checker #(
    parameter int DIM_W     = 7,
    parameter int CNT_W     = 8,
    parameter int REG_ELEMS = 128,
    localparam int CFG_W = 3 * (DIM_W + 1) + 3,
    localparam int IDX_W = 3 * DIM_W + 2,
    localparam int POS_W = CNT_W + 3 * DIM_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CFG_W-1:0] cfg_in,
    input logic             start,
    input logic             step,
    input logic             restore,
    input logic [POS_W-1:0] pos_load,
    input logic [POS_W-1:0] pos_save,
    input logic [IDX_W-1:0] idx_out,
    input logic             idx_valid,
    input logic             done,
    input logic             illegal
);

    localparam int PERM_LSB = 3 * (DIM_W + 1);

    AST_VALID_NEEDS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        idx_valid |-> $past(step));                                            // R3

    AST_BAD_PERM_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (start && cfg_in[PERM_LSB +: 3] > 3'd5) |=> illegal);                  // R7

    AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        idx_valid |-> (idx_out < IDX_W'(REG_ELEMS)));                          // R8

    AST_VALID_NOT_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        !(idx_valid && illegal));                                              // R8

    AST_DONE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start && !restore) |=> !idx_valid);                          // R9

    AST_RESTORE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (restore && !start) |=> (pos_save == $past(pos_load)));                // R10

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !step && !restore) |=>
            ($stable(idx_out) && $stable(pos_save) && !idx_valid));            // R11

endmodule

bind perm_index_walker pw_checker #(
    .DIM_W     (DIM_W),
    .CNT_W     (CNT_W),
    .REG_ELEMS (REG_ELEMS)
) u_pw_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_in    (cfg_in),
    .start     (start),
    .step      (step),
    .restore   (restore),
    .pos_load  (pos_load),
    .pos_save  (pos_save),
    .idx_out   (idx_out),
    .idx_valid (idx_valid),
    .done      (done),
    .illegal   (illegal)
);

// File: tb/perm_index_walker_bench.sv
`timescale 1ns/1ps
module perm_index_walker_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [26:0] cfg_in = '0;
    logic [7:0]  vec_len = '0;
    logic        start = 1'b0;
    logic        step = 1'b0;
    logic        restore = 1'b0;
    logic [28:0] pos_load = '0;
    logic [28:0] pos_save;
    logic [22:0] idx_out;
    logic        idx_valid;
    logic        done;
    logic        illegal;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    perm_index_walker u_perm_index_walker (
        .clk(clk), .rst_n(rst_n), .cfg_in(cfg_in), .vec_len(vec_len),
        .start(start), .step(step), .restore(restore), .pos_load(pos_load),
        .pos_save(pos_save), .idx_out(idx_out), .idx_valid(idx_valid),
        .done(done), .illegal(illegal)
    );

    // {config word, vector length}
    localparam logic [34:0] VECTORS [9] = '{
        {27'h2040302, 8'd60},   // x3 y4 z5, order (y,x,z)
        {27'h0840382, 8'd20},   // x3 y4 z5, order (x,y,z), offset 5
        {27'h5010201, 8'd12},   // x2 y3 z2, order (z,y,x)
        {27'h1020101, 8'd12},   // x2 y2 z3, order (x,z,y)
        {27'h3020101, 8'd12},   // order (y,z,x)
        {27'h4020101, 8'd12},   // order (z,x,y)
        {27'h0000101, 8'd10},   // 2x2x1 wraps within 10 steps
        {27'h0000000, 8'd8},    // all zero: linear
        {27'h2818181, 8'd8}     // 2x2x2, offset 7, order (y,x,z)
    };

    function automatic int model_idx(input logic [26:0] cfg, input int k);
        int lim [3];
        int pos [3];
        int ord [3];
        int off;
        if (cfg == '0) return k;
        lim[0] = int'(cfg[6:0]) + 1;
        lim[1] = int'(cfg[14:8]) + 1;
        lim[2] = int'(cfg[22:16]) + 1;
        off = int'({cfg[23], cfg[15], cfg[7]});
        case (cfg[26:24])
            3'd1: ord = '{0, 2, 1};
            3'd2: ord = '{1, 0, 2};
            3'd3: ord = '{1, 2, 0};
            3'd4: ord = '{2, 0, 1};
            3'd5: ord = '{2, 1, 0};
            default: ord = '{0, 1, 2};
        endcase
        pos = '{0, 0, 0};
        for (int s = 0; s < k; s++) begin
            for (int j = 0; j < 3; j++) begin
                pos[ord[j]] = pos[ord[j]] + 1;
                if (pos[ord[j]] != lim[ord[j]]) break;
                pos[ord[j]] = 0;
            end
        end
        return off + pos[0] + pos[1] * lim[0] + pos[2] * lim[0] * lim[1];
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_start(input logic [26:0] c, input logic [7:0] n);
        cfg_in = c; vec_len = n; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic do_step();
        step = 1'b1;
        @(negedge clk);
        step = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [28:0] saved;
        logic [22:0] held;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 valid", int'(idx_valid), 0);
        check("R1 done", int'(done), 0);
        check("R1 illegal", int'(illegal), 0);
        check("R1 idx", int'(idx_out), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R4 R5 R6 R9: table walk
        foreach (VECTORS[v]) begin
            logic [26:0] c;
            int n;
            c = VECTORS[v][34:8];
            n = int'(VECTORS[v][7:0]);
            do_start(c, VECTORS[v][7:0]);
            check("R9 done cleared on start", int'(done), 0);
            for (int k = 0; k < n; k++) begin
                do_step();
                check("R3 valid", int'(idx_valid), 1);
                check("R4 R2 R5 R6 index", int'(idx_out), model_idx(c, k));
                check("R6 no illegal", int'(illegal), 0);
                check("R9 done timing", int'(done), (k == n - 1) ? 1 : 0);
            end
            do_step();
            check("R9 step after done", int'(idx_valid), 0);
        end

        // R11 hold with no request
        do_start(27'h2040302, 8'd60);
        do_step();
        held = idx_out;
        saved = pos_save;
        repeat (3) @(negedge clk);
        check("R11 valid low", int'(idx_valid), 0);
        check("R11 idx held", int'(idx_out), int'(held));
        check("R11 pos held", int'(pos_save), int'(saved));

        // R10 save and restore
        do_start(27'h2040302, 8'd60);
        for (int k = 0; k < 10; k++) do_step();
        saved = pos_save;
        check("R10 saved count", int'(saved[28:21]), 10);
        repeat (3) do_step();
        do_start(27'h0840382, 8'd20);
        do_step();
        pos_load = saved; cfg_in = 27'h2040302; vec_len = 8'd60; restore = 1'b1;
        @(negedge clk);
        restore = 1'b0;
        check("R10 pos reloaded", int'(pos_save), int'(saved));
        do_step();
        check("R10 resume idx", int'(idx_out), model_idx(27'h2040302, 10));
        do_step();
        check("R10 next idx", int'(idx_out), model_idx(27'h2040302, 11));

        // R7 illegal permute codes
        for (int p = 6; p < 8; p++) begin
            do_start(27'h0020101 | (27'(p) << 24), 8'd4);
            check("R7 illegal raised", int'(illegal), 1);
            do_step();
            check("R7 no valid", int'(idx_valid), 0);
        end
        do_start(27'h0020101, 8'd4);
        check("R7 cleared by good start", int'(illegal), 0);

        // R8 register-file overrun: x=128, offset 7
        do_start(27'h08080FF, 8'd200);
        for (int k = 0; k < 121; k++) begin
            do_step();
            if (k == 120) begin
                check("R8 last legal idx", int'(idx_out), 127);
                check("R8 last legal valid", int'(idx_valid), 1);
            end
        end
        do_step();
        check("R8 overrun no valid", int'(idx_valid), 0);
        check("R8 overrun illegal", int'(illegal), 1);
        check("R8 position count held", int'(pos_save[28:21]), 121);
        check("R8 position x held", int'(pos_save[6:0]), 121);

        finish_run();
    end

endmodule